// File: doc/BRIEF.md
# TDM Per-Channel Output Selector

This block is the output stage of a time-slot interchange switch. It holds one 16-bit connection word for every output stream and channel. Software writes these words through a processor port. In every timeslot the block reads the word for each output stream and chooses the byte to send. The byte can come from the backplane input data memory or the local input data memory, or it can be a fixed message byte held in the word itself. Each word also carries an enable bit for its channel, and that bit drives a per-stream enable output.

Processor writes go to a shadow copy of the connection memory. The shadow copy becomes active at the next frame boundary, so a channel never mixes old and new settings within one frame. Both input data memories are filled through plain write ports from the input side. The processor can read the backplane data memory as 16-bit words, with the upper byte zero. Stream and channel counts are parameters. A processor or input-side address carries the channel number in its low log2(NUM_CHANNELS) bits and the stream number in the bits above.

Top module: `tsi_output_selector`

## Requirements
- R1: After a synchronous active-low reset, every `out_en` bit is 0, `out_data` is zero, `out_chan` is NUM_CHANNELS-1, and every connection word and backplane byte reads back as zero.
- R2: A word with bit 14 = 0, bit 15 = 0 and bit 13 = 1 outputs the backplane byte at stream = bits 12:9 and channel = bits 7:0.
- R3: A word with bit 14 = 0, bit 15 = 1 and bit 13 = 1 outputs the local byte at the same stream and channel address.
- R4: A word with bit 14 = 1 outputs its bits 7:0, whatever bit 15 and bits 12:9 hold.
- R5: Bit 13 of the word is copied to that stream's `out_en`. When bit 13 is 0, that stream's `out_data` byte is 0x00.
- R6: On a clock edge with `slot_tick` high, the outputs take the result for the current slot, and `out_chan` steps by one, wrapping after NUM_CHANNELS-1. Without `slot_tick`, all outputs hold their values.
- R7: A processor write changes the output only from slot 0 of the frame that starts after the next boundary tick. A boundary tick is a tick that presents slot NUM_CHANNELS-1. Until then, the old word stays in force.
- R8: A read with `cpu_rd_sel` = 0 returns the written (shadow) connection word at once. A read with `cpu_rd_sel` = 1 returns {8'h00, backplane byte}. Read data appears on the clock edge after `cpu_rd_en`.
- R9: With `lsb_first` = 1, the output byte is bit-reversed (bit 0 swaps with bit 7), for switched bytes and message bytes alike.
- R10: A source stream ≥ NUM_STREAMS or a source channel ≥ NUM_CHANNELS yields byte 0x00. A processor write to a stream ≥ NUM_STREAMS is ignored, and a read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_tick | input | 1 | Advance one timeslot |
| lsb_first | input | 1 | 1: bit-reverse output bytes |
| cpu_wr_en | input | 1 | Connection word write strobe |
| cpu_rd_en | input | 1 | Read strobe |
| cpu_rd_sel | input | 1 | 0: connection memory, 1: backplane data |
| cpu_addr | input | 14 | {stream, channel} address |
| cpu_wdata | input | 16 | Connection word to write |
| cpu_rdata | output | 16 | Registered read data |
| bp_wr_en | input | 1 | Backplane data write strobe |
| bp_wr_addr | input | 14 | Backplane {stream, channel} |
| bp_wr_data | input | 8 | Backplane byte |
| loc_wr_en | input | 1 | Local data write strobe |
| loc_wr_addr | input | 14 | Local {stream, channel} |
| loc_wr_data | input | 8 | Local byte |
| out_data | output | NUM_STREAMS*8 | Output byte per stream, stream s at bits 8s+7:8s |
| out_en | output | NUM_STREAMS | Output enable per stream |
| out_chan | output | log2(NUM_CHANNELS) | Channel currently presented |

## Verification
The bench builds the block with NUM_STREAMS = 4 and NUM_CHANNELS = 8. With only four streams, the 4-bit stream field can name streams 4 to 15, and an 8-bit channel number can point past channel 7. This lets the bench exercise out-of-range sources and ignored processor writes. An eight-slot frame gives a frame boundary every eight ticks. The bench can therefore place a write in the middle of a frame and follow both the old and the new setting across two whole frames.

// File: rtl/tsi_pkg.sv
// Shared definitions for the timeslot output selector.
// Assumes a 14-bit processor address and 16-bit connection words.
package tsi_pkg;
    localparam int CPU_AW = 14;

    // Connection word layout; bit positions are decoded by the selector.
    typedef struct packed {
        logic       src_local;
        logic       msg_mode;
        logic       chan_en;
        logic [3:0] src_stream;
        logic       spare;
        logic [7:0] low_byte;
    } conn_word_t;

    // Mirror a byte end for end.
    function automatic logic [7:0] bit_reverse(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction
endpackage

// File: rtl/tsi_data_mem.sv
// Byte-wide data store with one write port and NRD combinational read ports.
// Assumes the caller keeps every index below DEPTH.
module tsi_data_mem #(
    parameter int DEPTH = 32,
    parameter int NRD   = 4,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [NRD*IW-1:0] rd_idx,
    output logic [NRD*8-1:0]  rd_data
);
    logic [7:0] mem [DEPTH];

    // Clear on reset, otherwise store one byte per write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        // Read port r.
        assign rd_data[r*8 +: 8] = mem[rd_idx[r*IW +: IW]];
    end
endmodule

// File: rtl/tsi_conn_mem.sv
// Connection memory: a shadow copy written by the processor and an active
// copy used for output, refreshed from the shadow when commit is high.
// Assumes NUM_CHANNELS is a power of two.
module tsi_conn_mem #(
    parameter int NUM_STREAMS  = 4,
    parameter int NUM_CHANNELS = 8,
    localparam int DEPTH = NUM_STREAMS * NUM_CHANNELS,
    localparam int IW    = $clog2(DEPTH),
    localparam int CH_W  = $clog2(NUM_CHANNELS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IW-1:0]             wr_idx,
    input  logic [15:0]               wr_data,
    input  logic                      commit,
    input  logic [IW-1:0]             cpu_idx,
    output logic [15:0]               cpu_word,
    input  logic [CH_W-1:0]           slot,
    output logic [NUM_STREAMS*16-1:0] slot_words
);
    logic [15:0] shadow [DEPTH];
    logic [15:0] active [DEPTH];

    // Processor writes land in the shadow copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) shadow[i] <= '0;
        end else if (wr_en) begin
            shadow[wr_idx] <= wr_data;
        end
    end

    // The active copy follows the shadow only at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) active[i] <= '0;
        end else if (commit) begin
            active <= shadow;
        end
    end

    assign cpu_word = shadow[cpu_idx];

    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_slot
        localparam logic [IW-1:0] BASE = IW'(s * NUM_CHANNELS);
        logic [IW-1:0] idx;
        // Word for stream s in the current slot.
        assign idx = BASE + IW'(slot);
        assign slot_words[s*16 +: 16] = active[idx];
    end
endmodule

// File: rtl/tsi_chan_select.sv
// Per-stream decision logic: decodes one connection word, forms the data
// memory index, and picks the output byte and enable. Purely combinational.
module tsi_chan_select
    import tsi_pkg::*;
#(
    parameter int NUM_STREAMS  = 4,
    parameter int NUM_CHANNELS = 8,
    localparam int IW = $clog2(NUM_STREAMS * NUM_CHANNELS)
) (
    input  logic [15:0]   word,
    input  logic          lsb_first,
    output logic [IW-1:0] rd_idx,
    input  logic [7:0]    bp_byte,
    input  logic [7:0]    loc_byte,
    output logic [7:0]    sel_byte,
    output logic          sel_en
);
    conn_word_t cw;
    logic       in_range;
    logic [7:0] raw;
    logic       unused_spare;

    assign cw           = conn_word_t'(word);
    assign unused_spare = cw.spare;

    // Source address decode with range check.
    always_comb begin
        in_range = (int'(cw.src_stream) < NUM_STREAMS) &&
                   (int'(cw.low_byte) < NUM_CHANNELS);
        rd_idx   = in_range ?
                   IW'(int'(cw.src_stream) * NUM_CHANNELS + int'(cw.low_byte)) : '0;
    end

    // Choose message, local or backplane byte; blank when disabled.
    always_comb begin
        if (cw.msg_mode)      raw = cw.low_byte;
        else if (!in_range)   raw = 8'h00;
        else if (cw.src_local) raw = loc_byte;
        else                  raw = bp_byte;
        sel_en   = cw.chan_en;
        sel_byte = !cw.chan_en ? 8'h00 : (lsb_first ? bit_reverse(raw) : raw);
    end
endmodule

// File: rtl/tsi_output_selector.sv
// Output stage of a timeslot interchange: per output stream and channel a
// connection word picks a backplane byte, a local byte or a message byte.
// Assumes NUM_CHANNELS is a power of two, at least 2; NUM_STREAMS <= 16.
// Addresses are {stream, channel} with the channel in the low CH_W bits.
module tsi_output_selector
    import tsi_pkg::*;
#(
    parameter int NUM_STREAMS  = 4,
    parameter int NUM_CHANNELS = 8,
    localparam int CH_W  = $clog2(NUM_CHANNELS),
    localparam int DEPTH = NUM_STREAMS * NUM_CHANNELS,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     slot_tick,
    input  logic                     lsb_first,
    input  logic                     cpu_wr_en,
    input  logic                     cpu_rd_en,
    input  logic                     cpu_rd_sel,
    input  logic [13:0]              cpu_addr,
    input  logic [15:0]              cpu_wdata,
    output logic [15:0]              cpu_rdata,
    input  logic                     bp_wr_en,
    input  logic [13:0]              bp_wr_addr,
    input  logic [7:0]               bp_wr_data,
    input  logic                     loc_wr_en,
    input  logic [13:0]              loc_wr_addr,
    input  logic [7:0]               loc_wr_data,
    output logic [NUM_STREAMS*8-1:0] out_data,
    output logic [NUM_STREAMS-1:0]   out_en,
    output logic [CH_W-1:0]          out_chan
);
    localparam logic [CH_W-1:0] LAST_SLOT = CH_W'(NUM_CHANNELS - 1);

    // True when the stream part of an address names an existing stream.
    function automatic logic addr_ok(input logic [CPU_AW-1:0] a);
        return int'(a[CPU_AW-1:CH_W]) < NUM_STREAMS;
    endfunction

    // Flat memory index of an address, zero when out of range.
    function automatic logic [IW-1:0] addr_idx(input logic [CPU_AW-1:0] a);
        if (!addr_ok(a)) return '0;
        return IW'(int'(a[CPU_AW-1:CH_W]) * NUM_CHANNELS + int'(a[CH_W-1:0]));
    endfunction

    logic [CH_W-1:0]            cur_slot;
    logic                       frame_end;
    logic                       cpu_ok;
    logic [IW-1:0]              cpu_idx;
    logic [15:0]                cpu_word;
    logic [NUM_STREAMS*16-1:0]  slot_words;
    logic [NUM_STREAMS*IW-1:0]  sel_idx;
    logic [(NUM_STREAMS+1)*IW-1:0] bp_rd_idx;
    logic [(NUM_STREAMS+1)*8-1:0]  bp_rd_data;
    logic [NUM_STREAMS*8-1:0]   loc_rd_data;
    logic [NUM_STREAMS*8-1:0]   next_data;
    logic [NUM_STREAMS-1:0]     next_en;

    assign frame_end = slot_tick && (cur_slot == LAST_SLOT);
    assign cpu_ok    = addr_ok(cpu_addr);
    assign cpu_idx   = addr_idx(cpu_addr);
    assign bp_rd_idx = {cpu_idx, sel_idx};

    // Slot counter: one step per tick, wrapping at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)         cur_slot <= '0;
        else if (frame_end) cur_slot <= '0;
        else if (slot_tick) cur_slot <= cur_slot + 1'b1;
    end

    tsi_conn_mem #(.NUM_STREAMS(NUM_STREAMS), .NUM_CHANNELS(NUM_CHANNELS)) u_conn (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cpu_wr_en && cpu_ok),
        .wr_idx     (cpu_idx),
        .wr_data    (cpu_wdata),
        .commit     (frame_end),
        .cpu_idx    (cpu_idx),
        .cpu_word   (cpu_word),
        .slot       (cur_slot),
        .slot_words (slot_words)
    );

    tsi_data_mem #(.DEPTH(DEPTH), .NRD(NUM_STREAMS + 1)) u_bp_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bp_wr_en && addr_ok(bp_wr_addr)),
        .wr_idx  (addr_idx(bp_wr_addr)),
        .wr_data (bp_wr_data),
        .rd_idx  (bp_rd_idx),
        .rd_data (bp_rd_data)
    );

    tsi_data_mem #(.DEPTH(DEPTH), .NRD(NUM_STREAMS)) u_loc_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (loc_wr_en && addr_ok(loc_wr_addr)),
        .wr_idx  (addr_idx(loc_wr_addr)),
        .wr_data (loc_wr_data),
        .rd_idx  (sel_idx),
        .rd_data (loc_rd_data)
    );

    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
        tsi_chan_select #(.NUM_STREAMS(NUM_STREAMS), .NUM_CHANNELS(NUM_CHANNELS)) u_sel (
            .word      (slot_words[s*16 +: 16]),
            .lsb_first (lsb_first),
            .rd_idx    (sel_idx[s*IW +: IW]),
            .bp_byte   (bp_rd_data[s*8 +: 8]),
            .loc_byte  (loc_rd_data[s*8 +: 8]),
            .sel_byte  (next_data[s*8 +: 8]),
            .sel_en    (next_en[s])
        );
    end

    // Output registers: load the current slot's result on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            out_en   <= '0;
            out_chan <= LAST_SLOT;
        end else if (slot_tick) begin
            out_data <= next_data;
            out_en   <= next_en;
            out_chan <= cur_slot;
        end
    end

    // Processor read port: shadow word or zero-extended backplane byte.
    always_ff @(posedge clk) begin
        if (!rst_n)             cpu_rdata <= '0;
        else if (cpu_rd_en) begin
            if (!cpu_ok)        cpu_rdata <= '0;
            else if (cpu_rd_sel) cpu_rdata <= {8'h00, bp_rd_data[NUM_STREAMS*8 +: 8]};
            else                cpu_rdata <= cpu_word;
        end
    end
endmodule

// File: rtl/tsi_output_selector_chk.sv
// Checker for the output selector, attached by bind below.
// Assumes the same parameters as the bound instance.
module tsi_output_selector_chk #(
    parameter int NUM_STREAMS  = 4,
    parameter int NUM_CHANNELS = 8,
    localparam int CH_W = $clog2(NUM_CHANNELS)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     slot_tick,
    input logic                     cpu_rd_en,
    input logic                     cpu_rd_sel,
    input logic [15:0]              cpu_rdata,
    input logic [NUM_STREAMS*8-1:0] out_data,
    input logic [NUM_STREAMS-1:0]   out_en,
    input logic [CH_W-1:0]          out_chan
);
    localparam logic [CH_W-1:0] LAST_SLOT = CH_W'(NUM_CHANNELS - 1);

    logic noisy_idle;

    // Flag any disabled stream that still carries a nonzero byte.
    always_comb begin
        noisy_idle = 1'b0;
        for (int s = 0; s < NUM_STREAMS; s++)
            if (!out_en[s] && out_data[s*8 +: 8] != 8'h00) noisy_idle = 1'b1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (out_en == '0 && out_data == '0 && out_chan == LAST_SLOT));

    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !noisy_idle);

    assert_chan_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        slot_tick |=> out_chan == (($past(out_chan) == LAST_SLOT) ? '0 : $past(out_chan) + 1'b1));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_tick |=> ($stable(out_data) && $stable(out_en) && $stable(out_chan)));

    assert_rd_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd_en && cpu_rd_sel) |=> cpu_rdata[15:8] == 8'h00);
endmodule

bind tsi_output_selector tsi_output_selector_chk #(
    .NUM_STREAMS  (NUM_STREAMS),
    .NUM_CHANNELS (NUM_CHANNELS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_tick  (slot_tick),
    .cpu_rd_en  (cpu_rd_en),
    .cpu_rd_sel (cpu_rd_sel),
    .cpu_rdata  (cpu_rdata),
    .out_data   (out_data),
    .out_en     (out_en),
    .out_chan   (out_chan)
);

// File: tb/tsi_output_selector_test.sv
`timescale 1ns/1ps
module tsi_output_selector_test;
    localparam int NS = 4;
    localparam int NC = 8;
    localparam int CW = 3;

    logic clk = 0, rst_n = 0, slot_tick = 0, lsb_first = 0;
    logic cpu_wr_en = 0, cpu_rd_en = 0, cpu_rd_sel = 0;
    logic [13:0] cpu_addr = '0, bp_wr_addr = '0, loc_wr_addr = '0;
    logic [15:0] cpu_wdata = '0, cpu_rdata;
    logic bp_wr_en = 0, loc_wr_en = 0;
    logic [7:0] bp_wr_data = '0, loc_wr_data = '0;
    logic [NS*8-1:0] out_data;
    logic [NS-1:0] out_en;
    logic [CW-1:0] out_chan;

    int n_tests = 0, n_fail = 0;
    logic [7:0]  bp_m [NS*NC];
    logic [7:0]  loc_m [NS*NC];
    logic [15:0] conn_m [NS*NC];
    logic [15:0] shadow_m [NS*NC];
    logic [7:0]  exp_b [NS];
    logic        exp_e [NS];
    int          exp_chan = NC - 1;
    int          slot_nx = 0;

    always #4 clk = ~clk;

    tsi_output_selector #(.NUM_STREAMS(NS), .NUM_CHANNELS(NC)) uut (
        .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .lsb_first(lsb_first),
        .cpu_wr_en(cpu_wr_en), .cpu_rd_en(cpu_rd_en), .cpu_rd_sel(cpu_rd_sel),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .bp_wr_en(bp_wr_en), .bp_wr_addr(bp_wr_addr), .bp_wr_data(bp_wr_data),
        .loc_wr_en(loc_wr_en), .loc_wr_addr(loc_wr_addr), .loc_wr_data(loc_wr_data),
        .out_data(out_data), .out_en(out_en), .out_chan(out_chan)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_byte(logic [15:0] w, logic lsb);
        logic [7:0] b;
        int st, ch;
        if (!w[13]) return 8'h00;
        st = int'(w[12:9]);
        ch = int'(w[7:0]);
        if (w[14]) b = w[7:0];
        else if (st >= NS || ch >= NC) b = 8'h00;
        else b = w[15] ? loc_m[st*NC+ch] : bp_m[st*NC+ch];
        if (lsb) for (int i = 0; i < 8; i++) b[i] = (w[14] ? w[7-i] : b[i]);
        if (lsb && !w[14]) begin
            logic [7:0] t = b;
            for (int i = 0; i < 8; i++) b[i] = t[7-i];
        end
        return b;
    endfunction

    // One tick pulse; updates the expected outputs and the committed model.
    task automatic do_tick();
        int p = slot_nx;
        @(negedge clk) slot_tick = 1;
        @(negedge clk) slot_tick = 0;
        for (int s = 0; s < NS; s++) begin
            exp_b[s] = model_byte(conn_m[s*NC+p], lsb_first);
            exp_e[s] = conn_m[s*NC+p][13];
        end
        exp_chan = p;
        if (p == NC - 1) for (int i = 0; i < NS*NC; i++) conn_m[i] = shadow_m[i];
        slot_nx = (p + 1) % NC;
    endtask

    task automatic check_outputs(string req);
        for (int s = 0; s < NS; s++) begin
            chk(req, 32'(out_data[s*8 +: 8]), 32'(exp_b[s]));
            chk(req, 32'(out_en[s]), 32'(exp_e[s]));
        end
        chk(req, 32'(out_chan), 32'(exp_chan));
    endtask

    task automatic cpu_write(int addr, logic [15:0] d);
        @(negedge clk) begin cpu_wr_en = 1; cpu_addr = 14'(addr); cpu_wdata = d; end
        @(negedge clk) cpu_wr_en = 0;
        if (addr < NS*NC) shadow_m[addr] = d;
    endtask

    task automatic cpu_read(int addr, logic sel, output logic [15:0] d);
        @(negedge clk) begin cpu_rd_en = 1; cpu_rd_sel = sel; cpu_addr = 14'(addr); end
        @(negedge clk) cpu_rd_en = 0;
        d = cpu_rdata;
    endtask

    task automatic data_write(logic local_side, int idx, logic [7:0] d);
        @(negedge clk);
        if (local_side) begin loc_wr_en = 1; loc_wr_addr = 14'(idx); loc_wr_data = d; end
        else begin bp_wr_en = 1; bp_wr_addr = 14'(idx); bp_wr_data = d; end
        @(negedge clk) begin loc_wr_en = 0; bp_wr_en = 0; end
        if (local_side) loc_m[idx] = d; else bp_m[idx] = d;
    endtask

    // Pass a frame boundary, then check a whole frame slot by slot.
    task automatic commit_then_check(string req);
        do do_tick(); while (slot_nx != 0);
        for (int c = 0; c < NC; c++) begin
            do_tick();
            check_outputs(req);
        end
    endtask

    task automatic t_reset();
        logic [15:0] d;
        for (int s = 0; s < NS; s++) begin
            chk("R1 en", 32'(out_en[s]), 0);
            chk("R1 data", 32'(out_data[s*8 +: 8]), 0);
        end
        chk("R1 chan", 32'(out_chan), NC - 1);
        cpu_read(13, 0, d); chk("R1 conn", 32'(d), 0);
        cpu_read(13, 1, d); chk("R1 bp", 32'(d), 0);
    endtask

    task automatic fill_data();
        for (int i = 0; i < NS*NC; i++) begin
            data_write(0, i, 8'(8'h81 + i*5));
            data_write(1, i, 8'(8'h16 + i*11));
        end
    endtask

    task automatic t_backplane();
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < NC; c++)
                cpu_write(s*NC+c, {3'b001, 4'((s+1)%NS), 1'b0, 8'(NC-1-c)});
        commit_then_check("R2");
    endtask

    task automatic t_local();
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < NC; c++)
                cpu_write(s*NC+c, {3'b101, 4'((s+2)%NS), 1'b0, 8'(c)});
        commit_then_check("R3");
    endtask

    task automatic t_message();
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < NC; c++)
                cpu_write(s*NC+c, {(c % 2 == 1), 2'b11, 4'(c == 3 ? 1 : 15), 1'b0, 8'(8'hC0 + s*NC + c)});
        commit_then_check("R4");
    endtask

    task automatic t_disable();
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < NC; c++)
                cpu_write(s*NC+c, {2'b00, (c % 2 == 0), 4'(s), 1'b0, 8'(c)});
        commit_then_check("R5");
    endtask

    task automatic t_hold();
        do_tick();
        check_outputs("R6 tick");
        repeat (6) @(negedge clk);
        check_outputs("R6 hold");
    endtask

    task automatic t_lsb();
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < NC; c++)
                cpu_write(s*NC+c, (c < 4) ? {3'b001, 4'(s), 1'b0, 8'(c)}
                                          : {3'b011, 4'(0), 1'b0, 8'(8'h31 + c)});
        lsb_first = 1;
        commit_then_check("R9");
        lsb_first = 0;
    endtask

    task automatic t_range();
        logic [15:0] d;
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < NC; c++)
                cpu_write(s*NC+c, (c % 2 == 0) ? {3'b001, 4'(4 + s + c), 1'b0, 8'(c)}
                                                : {3'b101, 4'(s), 1'b0, 8'(8 + c*20)});
        commit_then_check("R10 src");
        cpu_write(NS*NC, 16'hFFFF);
        cpu_read(0, 0, d); chk("R10 alias", 32'(d), 32'(shadow_m[0]));
        cpu_read(NS*NC, 0, d); chk("R10 rd", 32'(d), 0);
    endtask

    task automatic t_commit();
        logic [15:0] d;
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < NC; c++)
                cpu_write(s*NC+c, {3'b011, 4'(0), 1'b0, 8'(8'h10 + c)});
        commit_then_check("R7 base");
        while (slot_nx != 3) do_tick();
        cpu_write(1*NC+5, {3'b011, 4'(0), 1'b0, 8'hEE});
        cpu_read(1*NC+5, 0, d); chk("R8 shadow", 32'(d), 32'h60EE);
        for (int k = 0; k < 2*NC; k++) begin
            do_tick();
            check_outputs("R7");
        end
    endtask

    task automatic t_readback();
        logic [15:0] d;
        cpu_read(2*NC+3, 1, d); chk("R8 bp", 32'(d), 32'({8'h00, bp_m[2*NC+3]}));
        cpu_read(3*NC+7, 1, d); chk("R8 bp", 32'(d), 32'({8'h00, bp_m[3*NC+7]}));
        cpu_read(2*NC+6, 0, d); chk("R8 conn", 32'(d), 32'(shadow_m[2*NC+6]));
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NS*NC; i++) begin
            bp_m[i] = '0; loc_m[i] = '0; conn_m[i] = '0; shadow_m[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        fill_data();
        t_backplane();
        t_local();
        t_message();
        t_disable();
        t_hold();
        t_lsb();
        t_range();
        t_commit();
        t_readback();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule